// File: doc/BRIEF.md
# Seven-to-One Parallel Link Serializer

The serializer turns a wide parallel word into a small set of serial lanes for a point-to-point board link. A new word is taken each time the word clock rises. Its bits are split across several data lanes, and each lane sends its share one bit per cycle of a bit clock that runs seven times faster and is phase-aligned to the word clock. A further lane carries a copy of the word clock built from the same bit slots, so the far end can recover word boundaries and the bit rate.

The whole block runs on the bit clock. It sees the word clock as a level and finds its rising edge at bit-clock resolution. An active-low sleep input turns off every lane enable. When the input is released, the block waits a set number of word periods while the far-end clock recovery settles. After that the first word sent is the first word captured. Words captured while the link is off or still settling are dropped. Each word passes through one holding register, so it leaves exactly one word period after it was captured. The sleep input is treated as synchronous to the bit clock.

Top module: `lnk_serializer`

## Requirements
- R1: While reset is held and right after it, `lane_oe`, `lane_fclk` and every bit of `lane_dat` are 0.
- R2: A word is captured at the first bit-clock rising edge at which `word_clk` is sampled high after being sampled low. Values on `par_word` at any other edge have no effect on what is sent.
- R3: Lane n sends bits n*SLOTS to n*SLOTS+SLOTS-1 of the captured word, with the lowest-numbered bit first (slot 0).
- R4: Each bit holds its lane for exactly one bit-clock cycle, and one word takes SLOTS (7) consecutive slots.
- R5: While enabled, `lane_fclk` is 1 in slots 0 to 3 and 0 in slots 4 to 6 of every word, so slot 0 lines up with its rising edge.
- R6: Slot 0 of a word captured at strobe edge E appears on the lanes right after the next strobe edge, SLOTS bit-clock cycles after E.
- R7: At the first bit-clock edge where `sleep_n` is sampled low, `lane_oe` goes to 0 and stays 0 while `sleep_n` is low. This holds mid-word too.
- R8: After `sleep_n` goes high, the first LOCK_WORDS strobes (counting the one at which it is first sampled high) only count the lock interval, and their words are dropped. The word at strobe LOCK_WORDS+1 is the first one sent, so `lane_oe` first rises at strobe LOCK_WORDS+2.
- R9: While `lane_oe` is 0, `lane_fclk` and all `lane_dat` bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock, SLOTS times the word rate, phase-aligned to `word_clk` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_clk | input | 1 | Word clock sampled as a level; its rising edge is the data strobe |
| sleep_n | input | 1 | Active-low power-down; low disables all lanes and clears the lock |
| par_word | input | LANES*SLOTS (28) | Parallel word to be sent |
| lane_dat | output | LANES (4) | Serial data lanes, one bit per bit-clock cycle |
| lane_fclk | output | 1 | Forwarded word-clock lane |
| lane_oe | output | 1 | Enable for all lanes; 0 stands for a high-impedance driver |

## Verification
Each kind of internal fault shows up at the ports within one word period.
- A lock counter that is off by one makes `lane_oe` rise one word early or late. The bench sees this at slot 0 of the first word after release, because its own count of strobes since release disagrees.
- A holding register that is skipped or loaded twice leaves the queue of expected words too short or too long at the next word boundary. It also shows as a word arriving under the wrong slot 0 of the forwarded clock.
- A slot or lane mapping error corrupts the 4-high, 3-low clock pattern or the bit order within the same word.
- A missed clear on sleep leaves `lane_oe` high for the cycle after `sleep_n` drops, and that cycle is checked directly.

// File: rtl/lnkser_pkg.sv
package lnkser_pkg;

  // Forwarded clock pattern for one word, slot 0 in bit 0: the first
  // ceil(slots/2) slots are high and the rest low.
  function automatic logic [31:0] fwd_pattern(input int unsigned slots);
    logic [31:0] pat;
    pat = '0;
    for (int unsigned i = 0; i < slots && i < 32; i++) begin
      pat[i] = (i < (slots + 1) / 2);
    end
    return pat;
  endfunction

endpackage

// File: rtl/lnk_word_strobe.sv
module lnk_word_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic word_clk,
  output logic stb
);
  logic wc_q;
  logic wc_d;

  always_comb begin
    wc_d = word_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wc_q <= 1'b0;
    else        wc_q <= wc_d;
  end

  assign stb = word_clk & ~wc_q;

  // R2
  stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

endmodule

// File: rtl/lnk_lock_ctrl.sv
module lnk_lock_ctrl #(
  parameter int unsigned LOCK_WORDS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic stb,
  output logic locked
);
  localparam int unsigned CNT_W = $clog2(LOCK_WORDS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lock_q, lock_d;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (!sleep_n) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else if (stb && !lock_q) begin
      if (cnt_q == CNT_W'(LOCK_WORDS - 1)) lock_d = 1'b1;
      else                                 cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;

  // R7
  sleep_clears_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !locked);

  // R8
  lock_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(stb));

endmodule

// File: rtl/lnk_lane_shift.sv
module lnk_lane_shift #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SLOTS-1:0] par,
  output logic             ser
);
  logic [SLOTS-1:0] sreg_q, sreg_d;

  always_comb begin
    if (load) sreg_d = par;
    else      sreg_d = sreg_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign ser = sreg_q[0];

endmodule

// File: rtl/lnk_serializer.sv
module lnk_serializer
  import lnkser_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned SLOTS      = 7,
  parameter int unsigned LOCK_WORDS = 8
) (
  input  logic                   clk_bit,
  input  logic                   rst_n,
  input  logic                   word_clk,
  input  logic                   sleep_n,
  input  logic [LANES*SLOTS-1:0] par_word,
  output logic [LANES-1:0]       lane_dat,
  output logic                   lane_fclk,
  output logic                   lane_oe
);
  localparam int unsigned    WORD_W   = LANES * SLOTS;
  localparam logic [SLOTS-1:0] FCLK_PAT = SLOTS'(fwd_pattern(SLOTS));

  // Reset: asserted asynchronously, released after two bit-clock edges
  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic stb;
  logic locked;

  lnk_word_strobe u_strobe (
    .clk      (clk_bit),
    .rst_n    (rst_s),
    .word_clk (word_clk),
    .stb      (stb)
  );

  lnk_lock_ctrl #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
    .clk     (clk_bit),
    .rst_n   (rst_s),
    .sleep_n (sleep_n),
    .stb     (stb),
    .locked  (locked)
  );

  // Holding register: one word period between capture and transmission
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              hold_en;
  logic              hvld_q, hvld_d;
  logic              send_q, send_d;

  always_comb begin
    hold_en = stb & sleep_n;
    hold_d  = hold_q;
    hvld_d  = hvld_q;
    send_d  = send_q;
    if (!sleep_n) begin
      hvld_d = 1'b0;
      send_d = 1'b0;
    end else if (stb) begin
      hold_d = par_word;
      hvld_d = locked;
      send_d = hvld_q;
    end
  end

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  always_ff @(posedge clk_bit or negedge rst_s) begin
    if (!rst_s) begin
      hvld_q <= 1'b0;
      send_q <= 1'b0;
    end else begin
      hvld_q <= hvld_d;
      send_q <= send_d;
    end
  end

  // Serial lanes: data lanes plus one forwarded clock lane
  logic [LANES-1:0] lane_ser;
  logic             fclk_ser;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lnk_lane_shift #(.SLOTS(SLOTS)) u_shift (
      .clk   (clk_bit),
      .rst_n (rst_s),
      .load  (stb),
      .par   (hold_q[g*SLOTS +: SLOTS]),
      .ser   (lane_ser[g])
    );
  end

  lnk_lane_shift #(.SLOTS(SLOTS)) u_fclk (
    .clk   (clk_bit),
    .rst_n (rst_s),
    .load  (stb),
    .par   (FCLK_PAT),
    .ser   (fclk_ser)
  );

  assign lane_dat  = lane_ser & {LANES{send_q}};
  assign lane_fclk = fclk_ser & send_q;
  assign lane_oe   = send_q;

  // R7
  sleep_disables_chk: assert property (@(posedge clk_bit) disable iff (!rst_s)
    !sleep_n |=> !lane_oe);

  // R8
  oe_needs_lock_chk: assert property (@(posedge clk_bit) disable iff (!rst_s)
    lane_oe |-> locked);

  // R5
  fclk_first_slot_chk: assert property (@(posedge clk_bit) disable iff (!rst_s)
    $rose(lane_oe) |-> lane_fclk);

  // R9
  quiet_when_off_chk: assert property (@(posedge clk_bit) disable iff (!rst_s)
    !lane_oe |-> (lane_dat == '0 && !lane_fclk));

  // R6
  oe_on_strobe_chk: assert property (@(posedge clk_bit) disable iff (!rst_s)
    $rose(lane_oe) |-> $past(stb));

endmodule

// File: tb/test_lnk_serializer.sv
module test_lnk_serializer;
  localparam int unsigned LANES  = 4;
  localparam int unsigned SLOTS  = 7;
  localparam int unsigned LOCK   = 4;
  localparam int unsigned WORD_W = LANES * SLOTS;

  logic              clk_bit = 1'b0;
  logic              rst_n, word_clk, sleep_n;
  logic [WORD_W-1:0] par_word;
  logic [LANES-1:0]  lane_dat;
  logic              lane_fclk, lane_oe;

  int checks = 0;
  int fails  = 0;

  logic [WORD_W-1:0] exp_q[$];
  int   since     = 0;
  bit   prev_sent = 1'b0;
  bit   mon_on    = 1'b0;

  always #5 clk_bit = ~clk_bit;

  lnk_serializer #(.LANES(LANES), .SLOTS(SLOTS), .LOCK_WORDS(LOCK)) i_lnk_serializer (
    .clk_bit   (clk_bit),
    .rst_n     (rst_n),
    .word_clk  (word_clk),
    .sleep_n   (sleep_n),
    .par_word  (par_word),
    .lane_dat  (lane_dat),
    .lane_fclk (lane_fclk),
    .lane_oe   (lane_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops a word at slot 0 and compares every slot (R3, R4, R5, R9)
  int                unsigned slot = 0;
  logic [WORD_W-1:0] cur = '0;
  always @(negedge clk_bit) begin
    if (mon_on) begin
      if (lane_oe) begin
        if (slot == 0) begin
          chk(exp_q.size() != 0, "R8 enabled with no word due", 32'(exp_q.size()), 32'd1);
          if (exp_q.size() != 0) cur = exp_q.pop_front();
        end
        begin
          logic [LANES:0] exp_v;
          exp_v[LANES] = (slot < 4);
          for (int n = 0; n < LANES; n++) exp_v[n] = cur[n*SLOTS + slot];
          chk({lane_fclk, lane_dat} == exp_v, "R3/R4/R5 slot bits",
              32'({lane_fclk, lane_dat}), 32'(exp_v));
        end
        slot = (slot == SLOTS - 1) ? 0 : slot + 1;
      end else begin
        slot = 0;
        chk(lane_dat == '0 && !lane_fclk, "R9 lanes quiet when off",
            32'({lane_fclk, lane_dat}), 32'd0);
      end
    end
  end

  // Driver: one word period; garbage on par_word outside the strobe (R2)
  task automatic drive_word(input logic [WORD_W-1:0] w, input bit run, input int drop_at);
    bit exp_oe;
    for (int p = 0; p < SLOTS; p++) begin
      @(negedge clk_bit);
      if (p == 1) chk(lane_oe == exp_oe, "R6/R8 lane_oe at slot 0", 32'(lane_oe), 32'(exp_oe));
      if (drop_at >= 0 && p == drop_at + 1)
        chk(lane_oe == 1'b0, "R7 mid-word sleep", 32'(lane_oe), 32'd0);
      word_clk = (p < 4);
      if (p == 0) begin
        par_word = w;
        if (sleep_n)
          chk(exp_q.size() == (prev_sent ? 1 : 0), "R6 words in flight",
              32'(exp_q.size()), 32'(prev_sent));
        exp_oe = run && prev_sent;
        if (!run) begin
          sleep_n   = 1'b0;
          exp_q.delete();
          since     = 0;
          prev_sent = 1'b0;
        end else begin
          sleep_n = 1'b1;
          since++;
          prev_sent = (since > LOCK);
          if (prev_sent) exp_q.push_back(w);
        end
      end else begin
        par_word = WORD_W'($urandom);
      end
      if (p == drop_at) begin
        sleep_n   = 1'b0;
        exp_q.delete();
        since     = 0;
        prev_sent = 1'b0;
      end
    end
  endtask

  function automatic logic [WORD_W-1:0] pat(input int i);
    case (i % 5)
      0:       return WORD_W'(i * 28'h0123457);
      1:       return WORD_W'(1) << (i % WORD_W);
      2:       return '1;
      3:       return {(WORD_W/2){2'b01}};
      default: return WORD_W'($urandom);
    endcase
  endfunction

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sleep_n = 1'b0; word_clk = 1'b0; par_word = '0;
    repeat (4) @(negedge clk_bit);
    // R1 outputs during reset
    chk(lane_oe == 0 && lane_dat == 0 && lane_fclk == 0, "R1 reset outputs",
        32'({lane_oe, lane_fclk, lane_dat}), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_bit);
    chk(lane_oe == 0 && lane_dat == 0 && lane_fclk == 0, "R1 after reset",
        32'({lane_oe, lane_fclk, lane_dat}), 32'd0);
    mon_on = 1'b1;

    // link off: words ignored (R7)
    for (int i = 0; i < 2; i++) drive_word(pat(i), 1'b0, -1);
    // release, lock interval, then patterned traffic (R8, R2, R3)
    for (int i = 0; i < LOCK + 10; i++) drive_word(pat(i), 1'b1, -1);
    // sleep at a word boundary (R7)
    drive_word(pat(3), 1'b0, -1);
    drive_word(pat(4), 1'b0, -1);
    // second release with random words, then a mid-word sleep (R7, R8)
    for (int i = 0; i < LOCK + 6; i++) drive_word(WORD_W'($urandom), 1'b1, -1);
    drive_word(pat(2), 1'b1, 3);
    drive_word(pat(1), 1'b0, -1);
    // quick re-release to check the lock count restarts (R8)
    for (int i = 0; i < LOCK + 4; i++) drive_word(pat(i + 7), 1'b1, -1);
    drive_word('0, 1'b0, -1);
    drive_word('0, 1'b0, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule